// File: doc/BRIEF.md
# Power Mode Controller

This block steps a small microcontroller core through three power states: run, idle and power-down. Software enters a low-power state by writing a two-bit power-control word. Bit 0 asks for idle and bit 1 asks for power-down. The block turns the state into clock-enable outputs for the CPU, the watchdog, the two timers, the real-time clock/buzzer timer and the oscillator. It also holds program-store-enable low while power-down lasts.

Idle stops only the CPU clock, and any enabled interrupt request ends it. Power-down stops every clock, including the oscillator. Only the two external interrupt lines or a long enough reset pulse can end it. Either wake passes through an oscillator stabilization wait before the CPU clock returns. An interrupt wake keeps all state, raises a slow-mode flag and asks the core to fetch the interrupt vector. A reset wake holds the core in reset and returns it to the power-on state.

Clock gating is expressed only as enables. The oscillator, the CPU, interrupt prioritisation and supply control are outside the block.

Top module: `pmc_top`

## Requirements
- R1: After rst_ni is released the block is in run: cpu_clk_en_o, osc_en_o, wdt_clk_en_o and tmr_clk_en_o are 1, while slow_mode_o, psen_hold_o, core_rst_o and wake_vec_req_o are 0.
- R2: In run, a write (wr_en_i=1) with wr_data_i=2'b01 enters idle at the next clock edge. In idle, cpu_clk_en_o is 0 and osc_en_o and wdt_clk_en_o are 1.
- R3: In idle, any bit of irq_i or ext_int_i returns the block to run at the next edge. wake_vec_req_o is then 1 for exactly one cycle, the first cycle with cpu_clk_en_o at 1.
- R4: In run, a write with wr_data_i[1]=1 enters power-down at the next edge. In power-down, osc_en_o, cpu_clk_en_o, wdt_clk_en_o, tmr_clk_en_o and rtc_clk_en_o are all 0, and psen_hold_o is 1.
- R5: In power-down, irq_i has no effect: the block stays in power-down with osc_en_o at 0.
- R6: In power-down, ext_int_i starts stabilization at the next edge. During stabilization osc_en_o is 1 and cpu_clk_en_o stays 0 for exactly STAB_CYCLES (default 16384) cycles. The block then returns to run with slow_mode_o=1, wake_vec_req_o pulsed for one cycle and core_rst_o at 0 throughout. The stabilization count restarts from zero on every power-down entry.
- R7: In power-down, ext_rst_i wakes the block only after it has been 1 for RST_MIN (default 24) consecutive cycles; a shorter pulse leaves the block in power-down. An accepted reset wake drives core_rst_o to 1 through stabilization and clears slow_mode_o. The following return to run gives no wake_vec_req_o pulse.
- R8: If the reset pulse completes in the same cycle that ext_int_i is 1 in power-down, the reset wake is taken.
- R9: A write with wr_data_i=2'b11 enters power-down, not idle.
- R10: rtc_clk_en_o follows lclk_tick_i in run and in idle. In idle, tmr_clk_en_o is 1 only on every 4th lclk_tick_i pulse counted from idle entry.
- R11: Power-control writes are ignored outside run: a write of 2'b10 during idle leaves the block in idle.
- R12: In run or idle, ext_rst_i=1 drives core_rst_o to 1, returns the block to run and clears slow_mode_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_i | input | 1 | Reset pin, active high |
| wr_en_i | input | 1 | Power-control write strobe |
| wr_data_i | input | 2 | Power-control write data: bit 0 idle, bit 1 power-down |
| irq_i | input | NUM_IRQ | Enabled internal interrupt requests |
| ext_int_i | input | 2 | External interrupt requests |
| lclk_tick_i | input | 1 | One-cycle pulse per low-speed clock period |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| wdt_clk_en_o | output | 1 | Watchdog clock enable |
| tmr_clk_en_o | output | 1 | Timer clock enable |
| rtc_clk_en_o | output | 1 | RTC and buzzer timer clock enable |
| psen_hold_o | output | 1 | Holds program-store-enable low |
| slow_mode_o | output | 1 | Core resumes in slow mode |
| wake_vec_req_o | output | 1 | Request to fetch the interrupt vector after a wake |
| core_rst_o | output | 1 | Reset to the core |

## Verification
Two wake sources can fall in the same power-down cycle: the reset pulse reaching its minimum width and an external interrupt. The bench holds ext_rst_i high and raises ext_int_i exactly on the 24th high cycle, so the two wakes coincide. It then judges the outcome. A correct reset wake shows core_rst_o high through stabilization, slow_mode_o low, and no vector request on return to run. An interrupt wake that slipped through would show the opposite on all three.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_DOWN = 2'd2,
    PM_STAB = 2'd3
  } pm_state_e;
endpackage

// File: rtl/pmc_wake_det.sv
module pmc_wake_det #(
  parameter int NUM_IRQ = 4,
  parameter int RST_MIN = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_idle_i,
  input  logic               in_down_i,
  input  logic               ext_rst_i,
  input  logic [1:0]         ext_int_i,
  input  logic [NUM_IRQ-1:0] irq_i,
  output logic               idle_wake_o,
  output logic               down_int_wake_o,
  output logic               down_rst_wake_o
);
  localparam int CW = $clog2(RST_MIN + 1);
  localparam logic [CW-1:0] LAST = CW'(RST_MIN - 1);

  logic [CW-1:0] rst_cnt_q;

  // consecutive high cycles of the reset pin, only counted in power-down
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      rst_cnt_q <= '0;
    else if (!in_down_i || !ext_rst_i) rst_cnt_q <= '0;
    else if (rst_cnt_q != LAST)        rst_cnt_q <= rst_cnt_q + 1'b1;
  end

  assign down_rst_wake_o = in_down_i && ext_rst_i && (rst_cnt_q == LAST);
  assign down_int_wake_o = in_down_i && (|ext_int_i) && !down_rst_wake_o;
  assign idle_wake_o     = in_idle_i && ((|ext_int_i) || (|irq_i));

  assert_rst_width_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (down_rst_wake_o && RST_MIN > 1) |-> $past(ext_rst_i));
endmodule

// File: rtl/pmc_stab_cnt.sv
module pmc_stab_cnt #(
  parameter int STAB_CYCLES = 16384
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = $clog2(STAB_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(STAB_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i || done_o) cnt_q <= '0;
    else if (run_i)           cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == LAST);

  assert_stab_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/pmc_clk_en.sv
module pmc_clk_en
  import pmc_pkg::*;
#(
  parameter int TMR_DIV = 4
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  pm_state_e state_i,
  input  logic      lclk_tick_i,
  output logic      cpu_clk_en_o,
  output logic      osc_en_o,
  output logic      wdt_clk_en_o,
  output logic      tmr_clk_en_o,
  output logic      rtc_clk_en_o,
  output logic      psen_hold_o
);
  localparam int DW = (TMR_DIV > 1) ? $clog2(TMR_DIV) : 1;
  localparam logic [DW-1:0] DLAST = DW'(TMR_DIV - 1);

  logic [DW-1:0] div_q;
  logic          div_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  div_q <= '0;
    else if (state_i != PM_IDLE)  div_q <= '0;
    else if (lclk_tick_i)         div_q <= div_hit ? '0 : div_q + 1'b1;
  end

  assign div_hit = (div_q == DLAST);

  always_comb begin
    cpu_clk_en_o = 1'b0;
    osc_en_o     = 1'b0;
    wdt_clk_en_o = 1'b0;
    tmr_clk_en_o = 1'b0;
    rtc_clk_en_o = 1'b0;
    psen_hold_o  = 1'b0;
    unique case (state_i)
      PM_RUN: begin
        cpu_clk_en_o = 1'b1;
        osc_en_o     = 1'b1;
        wdt_clk_en_o = 1'b1;
        tmr_clk_en_o = 1'b1;
        rtc_clk_en_o = lclk_tick_i;
      end
      PM_IDLE: begin
        osc_en_o     = 1'b1;
        wdt_clk_en_o = 1'b1;
        tmr_clk_en_o = lclk_tick_i && div_hit;
        rtc_clk_en_o = lclk_tick_i;
      end
      PM_DOWN: psen_hold_o = 1'b1;
      PM_STAB: begin
        osc_en_o    = 1'b1;
        psen_hold_o = 1'b1;
      end
      default: ;
    endcase
  end

  assert_down_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == PM_DOWN) |-> !(osc_en_o || cpu_clk_en_o || wdt_clk_en_o || tmr_clk_en_o || rtc_clk_en_o));
  assert_idle_tmr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == PM_IDLE && tmr_clk_en_o) |-> rtc_clk_en_o);
endmodule

// File: rtl/pmc_top.sv
module pmc_top
  import pmc_pkg::*;
#(
  parameter int NUM_IRQ     = 4,
  parameter int RST_MIN     = 24,
  parameter int STAB_CYCLES = 16384,
  parameter int TMR_DIV     = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ext_rst_i,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_data_i,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic [1:0]         ext_int_i,
  input  logic               lclk_tick_i,
  output logic               cpu_clk_en_o,
  output logic               osc_en_o,
  output logic               wdt_clk_en_o,
  output logic               tmr_clk_en_o,
  output logic               rtc_clk_en_o,
  output logic               psen_hold_o,
  output logic               slow_mode_o,
  output logic               wake_vec_req_o,
  output logic               core_rst_o
);
  pm_state_e state_q, state_d;
  logic idle_wake, down_int_wake, down_rst_wake, stab_done;
  logic kind_rst_q, slow_q, vec_q;
  logic wr_ok, awake_rst;

  pmc_wake_det #(.NUM_IRQ(NUM_IRQ), .RST_MIN(RST_MIN)) u_wake (
    .clk_i, .rst_ni,
    .in_idle_i       (state_q == PM_IDLE),
    .in_down_i       (state_q == PM_DOWN),
    .ext_rst_i, .ext_int_i, .irq_i,
    .idle_wake_o     (idle_wake),
    .down_int_wake_o (down_int_wake),
    .down_rst_wake_o (down_rst_wake)
  );

  pmc_stab_cnt #(.STAB_CYCLES(STAB_CYCLES)) u_stab (
    .clk_i, .rst_ni,
    .clr_i  (state_q == PM_DOWN),
    .run_i  (state_q == PM_STAB),
    .done_o (stab_done)
  );

  pmc_clk_en #(.TMR_DIV(TMR_DIV)) u_clk (
    .clk_i, .rst_ni,
    .state_i (state_q),
    .lclk_tick_i,
    .cpu_clk_en_o, .osc_en_o, .wdt_clk_en_o,
    .tmr_clk_en_o, .rtc_clk_en_o, .psen_hold_o
  );

  assign awake_rst = ext_rst_i && (state_q == PM_RUN || state_q == PM_IDLE);
  assign wr_ok     = wr_en_i && (state_q == PM_RUN) && !ext_rst_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PM_RUN:  if (wr_ok && wr_data_i[1]) state_d = PM_DOWN;  // power-down wins
               else if (wr_ok && wr_data_i[0]) state_d = PM_IDLE;
      PM_IDLE: if (ext_rst_i || idle_wake) state_d = PM_RUN;
      PM_DOWN: if (down_rst_wake || down_int_wake) state_d = PM_STAB;
      PM_STAB: if (stab_done) state_d = PM_RUN;
      default: state_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= PM_RUN;
      kind_rst_q <= 1'b0;
      slow_q     <= 1'b0;
      vec_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      if (down_rst_wake)      kind_rst_q <= 1'b1;
      else if (down_int_wake) kind_rst_q <= 1'b0;
      if (down_rst_wake || awake_rst) slow_q <= 1'b0;
      else if (down_int_wake)         slow_q <= 1'b1;
      vec_q <= (state_q == PM_IDLE && idle_wake && !ext_rst_i) || (stab_done && !kind_rst_q);
    end
  end

  assign slow_mode_o    = slow_q;
  assign wake_vec_req_o = vec_q;
  assign core_rst_o     = awake_rst || (state_q == PM_STAB && kind_rst_q);

  assert_idle_osc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PM_IDLE) |-> (osc_en_o && !cpu_clk_en_o));
  assert_vec_clean_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_vec_req_o |-> (cpu_clk_en_o && !core_rst_o));
  assert_down_entry_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && wr_data_i[1]) |=> (state_q == PM_DOWN));
  assert_stab_exit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == PM_STAB && state_q == PM_RUN) |-> $past(stab_done));
  assert_down_stay_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PM_DOWN && !ext_rst_i && ext_int_i == 2'b00) |=> (state_q == PM_DOWN));
endmodule

// File: tb/pmc_top_tb_top.sv
`timescale 1ns/1ps
module pmc_top_tb_top;
  localparam int NI = 4;
  localparam int RMIN = 24;
  localparam int STAB = 16384;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ext_rst = 0, wr_en = 0, lclk = 0;
  logic [1:0] wr_data = 0, ext_int = 0;
  logic [NI-1:0] irq = 0;
  logic cpu_en, osc_en, wdt_en, tmr_en, rtc_en, psen_hold, slow, vec, core_rst;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pmc_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ext_rst_i(ext_rst), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .irq_i(irq), .ext_int_i(ext_int), .lclk_tick_i(lclk),
    .cpu_clk_en_o(cpu_en), .osc_en_o(osc_en), .wdt_clk_en_o(wdt_en), .tmr_clk_en_o(tmr_en),
    .rtc_clk_en_o(rtc_en), .psen_hold_o(psen_hold), .slow_mode_o(slow),
    .wake_vec_req_o(vec), .core_rst_o(core_rst)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // advance one edge; inputs change 1ns after the edge, sampling at +2ns
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    ext_rst = 0; wr_en = 0; wr_data = 0; irq = 0; ext_int = 0; lclk = 0;
    rst_n = 0; tick(); tick(); rst_n = 1; tick();
  endtask

  task automatic write_pcon(input logic [1:0] d);
    wr_en = 1; wr_data = d; tick(); wr_en = 0; wr_data = 0;
  endtask

  task automatic t_reset_state();
    do_reset(); #1;
    chk("R1 cpu", cpu_en, 1); chk("R1 osc", osc_en, 1);
    chk("R1 wdt", wdt_en, 1); chk("R1 tmr", tmr_en, 1);
    chk("R1 slow", slow, 0);  chk("R1 psen", psen_hold, 0);
    chk("R1 rst", core_rst, 0); chk("R1 vec", vec, 0);
  endtask

  task automatic t_idle();
    do_reset();
    write_pcon(2'b01); #1;
    chk("R2 cpu", cpu_en, 0); chk("R2 osc", osc_en, 1); chk("R2 wdt", wdt_en, 1);
    write_pcon(2'b10); #1;
    chk("R11 still idle", cpu_en, 0); chk("R11 osc", osc_en, 1);
    for (int i = 1; i <= 4; i++) begin
      lclk = 1; #1;
      chk("R10 rtc idle", rtc_en, 1);
      chk("R10 tmr idle", tmr_en, (i == 4) ? 1 : 0);
      tick(); lclk = 0;
    end
    irq = 4'b0100; tick(); irq = 0; #1;
    chk("R3 cpu back", cpu_en, 1); chk("R3 vec", vec, 1);
    tick(); #1;
    chk("R3 vec one cycle", vec, 0);
    lclk = 1; #1; chk("R10 rtc run", rtc_en, 1); tick(); lclk = 0; #1;
    chk("R10 rtc run low", rtc_en, 0);
  endtask

  task automatic t_down_int();
    do_reset();
    write_pcon(2'b10); #1;
    chk("R4 osc", osc_en, 0); chk("R4 cpu", cpu_en, 0); chk("R4 wdt", wdt_en, 0);
    chk("R4 tmr", tmr_en, 0); chk("R4 psen", psen_hold, 1);
    lclk = 1; #1; chk("R4 rtc", rtc_en, 0); lclk = 0;
    irq = 4'b1111; tick(); tick(); irq = 0; #1;
    chk("R5 osc", osc_en, 0);
    ext_int = 2'b10; tick(); ext_int = 0; #1;
    chk("R6 osc stab", osc_en, 1); chk("R6 cpu stab", cpu_en, 0);
    for (int i = 1; i < STAB; i++) begin
      if (cpu_en !== 1'b0 || core_rst !== 1'b0) chk("R6 held", cpu_en + 2*core_rst, 0);
      tick();
    end
    #1; chk("R6 cpu last", cpu_en, 0);
    tick(); #1;
    chk("R6 cpu on", cpu_en, 1); chk("R6 slow", slow, 1);
    chk("R6 vec", vec, 1); chk("R6 rst", core_rst, 0);
  endtask

  task automatic t_both_bits();
    do_reset();
    write_pcon(2'b11); #1;
    chk("R9 osc", osc_en, 0); chk("R9 psen", psen_hold, 1);
  endtask

  task automatic t_down_rst();
    do_reset();
    write_pcon(2'b10);
    ext_int = 2'b01; tick(); ext_int = 0;   // short interrupt wake to set slow
    for (int i = 0; i < STAB; i++) tick();
    #1; chk("R6 slow set", slow, 1);
    write_pcon(2'b10);
    ext_rst = 1;
    for (int i = 0; i < RMIN - 1; i++) tick();
    ext_rst = 0; tick(); #1;
    chk("R7 short ignored", osc_en, 0);
    ext_rst = 1;
    for (int i = 0; i < RMIN - 1; i++) tick();
    ext_int = 2'b01;                        // coincides with 24th high cycle
    tick(); ext_rst = 0; ext_int = 0; #1;
    chk("R7 osc on", osc_en, 1); chk("R8 core rst", core_rst, 1);
    chk("R8 slow cleared", slow, 0);
    for (int i = 1; i < STAB; i++) tick();
    tick(); #1;
    chk("R7 run", cpu_en, 1); chk("R8 no vec", vec, 0); chk("R7 rst low", core_rst, 0);
  endtask

  task automatic t_run_rst();
    do_reset();
    write_pcon(2'b01);
    ext_rst = 1; #1; chk("R12 core rst idle", core_rst, 1);
    tick(); #1;
    chk("R12 run", cpu_en, 1); chk("R12 core rst run", core_rst, 1);
    write_pcon(2'b01); #1; chk("R12 write blocked", cpu_en, 1);
    ext_rst = 0; #1; chk("R12 released", core_rst, 0); chk("R12 slow", slow, 0);
  endtask

  initial begin
    t_reset_state();
    t_idle();
    t_down_int();
    t_both_bits();
    t_down_rst();
    t_run_rst();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule